// File: doc/BRIEF.md
# Instruction Word Write Assembler

This block builds 16-bit instruction memory writes out of pairs of 8-bit writes from a remote processor. The low byte of each word comes first and is parked in a holding register. Nothing is written to memory at that point. The high byte comes second. It is joined with the parked byte into a full word, and the active-low instruction write strobe is driven for one cycle plus a programmed number of wait states. When the strobe ends, the word address moves on by one.

A phase flag records whether the next byte is a low byte or a high byte. Reset clears the flag. Writing the instruction-memory code to the select register also clears it, so software can restore word alignment without resetting the block. The address can be loaded one byte at a time, and loading it leaves the phase flag as it is.

While a word write is in its wait states, a busy output is high and byte-write requests are ignored. The requester holds its request until busy falls.

Top module: `iword_assembler`

## Requirements
- R1: After reset `iwr_n` is 1, `busy` is 0, `wr_addr` is 0 and `word_out` is 0. The phase flag is clear, so the first byte is taken as a low byte.
- R2: A byte write accepted while the phase flag is clear stores `byte_data` as the low byte and sets the flag. `iwr_n` stays high and `wr_addr` does not change.
- R3: A byte write accepted while the phase flag is set drives `word_out` = {`byte_data`, stored low byte}. In the cycle after the accepting edge, `iwr_n` is 0.
- R4: A word write keeps `iwr_n` low for exactly `wait_cnt`+1 cycles. The value of `wait_cnt` used is the one sampled at the edge that accepts the high byte.
- R5: In the first cycle in which `iwr_n` is high again, `wr_addr` has gone up by 1 and the phase flag is clear.
- R6: A pulse on `sel_wr` with `sel_code` = 2'b01 clears the phase flag. Any other code leaves the flag unchanged.
- R7: `addr_ld_lo` loads `byte_data` into `wr_addr[7:0]`, and `addr_ld_hi` loads it into `wr_addr[15:8]`. A load does not change the phase flag, and a load takes priority over the increment.
- R8: `busy` is high while `iwr_n` is low. A `byte_wr` that arrives while `busy` is high is ignored: it does not change `word_out`, the stored low byte or the phase flag.
- R9: The address wraps from 16'hFFFF to 16'h0000 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_wr | input | 1 | Byte-write request |
| byte_data | input | 8 | Byte to write, also the data for address loads |
| wait_cnt | input | 2 | Number of instruction wait states |
| addr_ld_lo | input | 1 | Load the low address byte from byte_data |
| addr_ld_hi | input | 1 | Load the high address byte from byte_data |
| sel_wr | input | 1 | Select-register write strobe |
| sel_code | input | 2 | Memory select code being written |
| word_out | output | 16 | Assembled instruction word |
| iwr_n | output | 1 | Active-low instruction write strobe |
| busy | output | 1 | Word write in progress; requests are ignored |
| wr_addr | output | 16 | Current instruction word address |

## Verification
The bench drives inputs on falling edges and samples on the next falling edge.

- **Low byte:** results are checked one cycle after the accepting rising edge. The strobe must still be high and the address unchanged.
- **High byte:** the assembled word and the falling strobe are checked one cycle after the accepting edge. The bench then counts falling-edge samples with the strobe low, and the count must equal `wait_cnt`+1.
- **After the strobe:** the incremented address is checked in the first sample with the strobe high.
- **Phase flag:** a request is injected during each strobe, and select writes and address loads are issued between bytes. The effect of all three on the phase flag shows up in the word that the next byte pair produces.

// File: rtl/iwa_pkg.sv
package iwa_pkg;
   localparam logic [1:0] SEL_IMEM = 2'b01;
   typedef enum logic {EXPECT_LO = 1'b0, EXPECT_HI = 1'b1} byte_phase_e;
endpackage

// File: rtl/iwa_byte_track.sv
module iwa_byte_track
   import iwa_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic                sel_clr,
   input  logic                word_done,
   input  logic [BYTE_W-1:0]   byte_in,
   output logic                phase_hi,
   output logic [BYTE_W-1:0]   hold_byte,
   output logic [2*BYTE_W-1:0] word_q
);
   byte_phase_e phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= EXPECT_LO;
         hold_byte <= '0;
         word_q    <= '0;
      end else begin
         if (accept) begin
            if (phase == EXPECT_LO) begin
               hold_byte <= byte_in;
               phase     <= EXPECT_HI;
            end else begin
               word_q <= {byte_in, hold_byte};
            end
         end
         if (word_done || sel_clr) phase <= EXPECT_LO;
      end
   end

   assign phase_hi = (phase == EXPECT_HI);
endmodule

// File: rtl/iwa_strobe_timer.sv
module iwa_strobe_timer #(
   parameter int WS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WS_W-1:0] ws_in,
   output logic            active,
   output logic            done
);
   logic [WS_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= ws_in;
      end else if (done) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = active && (cnt == '0);
endmodule

// File: rtl/iwa_addr_ctr.sv
module iwa_addr_ctr #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BYTE_W-1:0] ld_byte,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] addr_ld;

   generate
      if (HI_W == BYTE_W) begin : g_full_hi
         assign addr_ld = {ld_hi ? ld_byte : addr[ADDR_W-1:BYTE_W],
                           ld_lo ? ld_byte : addr[BYTE_W-1:0]};
      end else begin : g_part_hi
         assign addr_ld = {ld_hi ? ld_byte[HI_W-1:0] : addr[ADDR_W-1:BYTE_W],
                           ld_lo ? ld_byte : addr[BYTE_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              addr <= '0;
      else if (ld_lo || ld_hi) addr <= addr_ld;
      else if (inc)            addr <= addr + 1'b1;
   end
endmodule

// File: rtl/iword_assembler.sv
module iword_assembler
   import iwa_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 16,
   parameter int WS_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                byte_wr,
   input  logic [BYTE_W-1:0]   byte_data,
   input  logic [WS_W-1:0]     wait_cnt,
   input  logic                addr_ld_lo,
   input  logic                addr_ld_hi,
   input  logic                sel_wr,
   input  logic [1:0]          sel_code,
   output logic [2*BYTE_W-1:0] word_out,
   output logic                iwr_n,
   output logic                busy,
   output logic [ADDR_W-1:0]   wr_addr
);
   generate
      if (BYTE_W < 2)                                  begin : g_bad_byte
         $error("BYTE_W too small");
      end
      if (ADDR_W <= BYTE_W || ADDR_W > 2*BYTE_W)       begin : g_bad_addr
         $error("ADDR_W must lie in (BYTE_W, 2*BYTE_W]");
      end
      if (WS_W < 1 || WS_W > 8)                        begin : g_bad_ws
         $error("WS_W out of range");
      end
   endgenerate

   logic              accept;
   logic              sel_clr;
   logic              phase_hi;
   logic [BYTE_W-1:0] hold_byte;
   logic              active;
   logic              word_done;

   assign accept  = byte_wr && !active;
   assign sel_clr = sel_wr && (sel_code == SEL_IMEM);

   iwa_byte_track #(.BYTE_W(BYTE_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .sel_clr   (sel_clr),
      .word_done (word_done),
      .byte_in   (byte_data),
      .phase_hi  (phase_hi),
      .hold_byte (hold_byte),
      .word_q    (word_out)
   );

   iwa_strobe_timer #(.WS_W(WS_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept && phase_hi),
      .ws_in  (wait_cnt),
      .active (active),
      .done   (word_done)
   );

   iwa_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (addr_ld_lo),
      .ld_hi   (addr_ld_hi),
      .ld_byte (byte_data),
      .inc     (word_done),
      .addr    (wr_addr)
   );

   assign busy  = active;
   assign iwr_n = !active;
endmodule

// File: rtl/iwa_checker.sv
module iwa_checker #(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 16,
   parameter int WS_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                byte_wr,
   input logic [BYTE_W-1:0]   byte_data,
   input logic                addr_ld_lo,
   input logic                addr_ld_hi,
   input logic                sel_wr,
   input logic [1:0]          sel_code,
   input logic [2*BYTE_W-1:0] word_out,
   input logic                iwr_n,
   input logic                busy,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic                phase_hi,
   input logic [BYTE_W-1:0]   hold_byte
);
   logic [WS_W+1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n)      low_run <= '0;
      else if (!iwr_n) low_run <= low_run + 1'b1;
      else             low_run <= '0;
   end

   // R2: low byte causes no strobe
   p_low_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && !busy && !phase_hi) |=> (iwr_n && phase_hi));

   // R3: high byte assembles the word and starts the strobe
   p_high_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && !busy && phase_hi) |=>
         (!iwr_n && word_out == {$past(byte_data), $past(hold_byte)}));

   // R4: strobe never longer than the largest wait count plus one
   p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= (WS_W+2)'(1 << WS_W));

   // R5: address steps by one when the strobe ends
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(iwr_n) && !$past(addr_ld_lo) && !$past(addr_ld_hi)) |->
         (wr_addr == $past(wr_addr) + 1'b1 && !phase_hi));

   // R6: select write of the instruction-memory code clears the phase
   p_sel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && sel_code == 2'b01) |=> !phase_hi);

   // R8: requests during busy leave the word and holding byte alone
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(word_out) && $stable(hold_byte)));
endmodule

bind iword_assembler iwa_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .WS_W(WS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_wr    (byte_wr),
   .byte_data  (byte_data),
   .addr_ld_lo (addr_ld_lo),
   .addr_ld_hi (addr_ld_hi),
   .sel_wr     (sel_wr),
   .sel_code   (sel_code),
   .word_out   (word_out),
   .iwr_n      (iwr_n),
   .busy       (busy),
   .wr_addr    (wr_addr),
   .phase_hi   (phase_hi),
   .hold_byte  (hold_byte)
);

// File: tb/sim_iword_assembler.sv
module sim_iword_assembler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_wr = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [1:0]  wait_cnt = '0;
   logic        addr_ld_lo = 1'b0;
   logic        addr_ld_hi = 1'b0;
   logic        sel_wr = 1'b0;
   logic [1:0]  sel_code = '0;
   logic [15:0] word_out;
   logic        iwr_n;
   logic        busy;
   logic [15:0] wr_addr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic        exp_hi = 1'b0;
   logic [7:0]  exp_hold = '0;
   logic [15:0] exp_addr = '0;
   logic [15:0] exp_word = '0;

   always #5 clk = ~clk;

   iword_assembler u0 (
      .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_data(byte_data),
      .wait_cnt(wait_cnt), .addr_ld_lo(addr_ld_lo), .addr_ld_hi(addr_ld_hi),
      .sel_wr(sel_wr), .sel_code(sel_code), .word_out(word_out),
      .iwr_n(iwr_n), .busy(busy), .wr_addr(wr_addr)
   );

   function automatic logic [15:0] join_word(input logic [7:0] hi, input logic [7:0] lo);
      return {hi, lo};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
      end
   endtask

   task automatic send_byte(input logic [7:0] d, input logic [1:0] ws);
      int lowc;
      logic was_hi;
      while (busy) @(negedge clk);
      was_hi    = exp_hi;
      byte_wr   = 1'b1;
      byte_data = d;
      wait_cnt  = ws;
      @(negedge clk);
      byte_wr  = 1'b0;
      wait_cnt = 2'($urandom);
      if (!was_hi) begin
         exp_hold = d;
         exp_hi   = 1'b1;
         chk(iwr_n == 1'b1, "R2 strobe", 32'(iwr_n), 32'd1);
         chk(wr_addr == exp_addr, "R2 addr", 32'(wr_addr), 32'(exp_addr));
      end else begin
         exp_word = join_word(d, exp_hold);
         chk(iwr_n == 1'b0, "R3 strobe", 32'(iwr_n), 32'd0);
         chk(word_out == exp_word, "R3 word", 32'(word_out), 32'(exp_word));
         chk(busy == 1'b1, "R8 busy", 32'(busy), 32'd1);
         lowc = 0;
         while (!iwr_n && lowc < 10) begin
            lowc++;
            if (lowc == 1) begin
               byte_wr   = 1'b1;     // R8: request during busy must be ignored
               byte_data = 8'($urandom);
            end else begin
               byte_wr = 1'b0;
            end
            @(negedge clk);
         end
         byte_wr = 1'b0;
         chk(lowc == int'(ws) + 1, "R4 strobe length", 32'(lowc), 32'(ws + 1));
         chk(word_out == exp_word, "R8 word held", 32'(word_out), 32'(exp_word));
         exp_addr = exp_addr + 16'd1;
         exp_hi   = 1'b0;
         chk(wr_addr == exp_addr, "R5 addr step", 32'(wr_addr), 32'(exp_addr));
      end
   endtask

   task automatic sel_write(input logic [1:0] code);
      sel_wr   = 1'b1;
      sel_code = code;
      @(negedge clk);
      sel_wr = 1'b0;
      if (code == 2'b01) exp_hi = 1'b0;
   endtask

   task automatic addr_load(input bit hi, input logic [7:0] v);
      byte_data = v;
      if (hi) addr_ld_hi = 1'b1; else addr_ld_lo = 1'b1;
      @(negedge clk);
      addr_ld_hi = 1'b0;
      addr_ld_lo = 1'b0;
      if (hi) exp_addr[15:8] = v; else exp_addr[7:0] = v;
      chk(wr_addr == exp_addr, "R7 load", 32'(wr_addr), 32'(exp_addr));
   endtask

   initial begin
      void'($urandom(32'h1f2e3d4c));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(iwr_n == 1'b1, "R1 iwr_n", 32'(iwr_n), 32'd1);
      chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
      chk(wr_addr == 16'h0, "R1 addr", 32'(wr_addr), 32'd0);
      chk(word_out == 16'h0, "R1 word", 32'(word_out), 32'd0);

      // R1/R2/R3: first pair, phase starts at low
      send_byte(8'h34, 2'd0);
      send_byte(8'h12, 2'd0);
      // R4: every wait count
      for (int w = 0; w < 4; w++) begin
         send_byte(8'(8'hA0 + w), 2'(w));
         send_byte(8'(8'h50 + w), 2'(w));
      end
      // R6: clear mid-pair with code 01
      send_byte(8'hEE, 2'd1);
      sel_write(2'b01);
      send_byte(8'h78, 2'd1);
      send_byte(8'h56, 2'd1);
      // R6: other code does not clear
      send_byte(8'h11, 2'd0);
      sel_write(2'b10);
      send_byte(8'h22, 2'd0);
      // R7: load mid-pair keeps phase
      send_byte(8'h9A, 2'd2);
      addr_load(1'b1, 8'hC0);
      addr_load(1'b0, 8'h05);
      send_byte(8'hBC, 2'd2);
      // R9: wrap
      addr_load(1'b1, 8'hFF);
      addr_load(1'b0, 8'hFF);
      send_byte(8'h01, 2'd3);
      send_byte(8'h02, 2'd3);
      chk(wr_addr == 16'h0000, "R9 wrap", 32'(wr_addr), 32'd0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int k;
         k = int'($urandom % 10);
         if (k < 7)      send_byte(8'($urandom), 2'($urandom));
         else if (k < 9) sel_write(2'($urandom));
         else            addr_load(1'($urandom), 8'($urandom));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule